// File: doc/BRIEF.md
# Per-Bank Interrupt Status Unit

This unit gathers event flags for several flash banks into one status register per bank and turns them into a single interrupt line. Each event input is watched for a low-to-high transition. A transition sets the matching status bit, and the bit then holds until it is cleared by writing a one to it. Each bank also has an enable register. A bank contributes to the interrupt when any of its status bits is set together with the matching enable bit. A global enable gates the final output.

Each bank has a ready/busy pin, where a high level means ready. The pin is resynchronised, and its rising edge sets the bank's ready bit, status bit 0. This happens only for banks selected in a pin-watch mask. A read-only capability register reports how many banks are built in, as the base-2 logarithm of the bank count.

Software reaches every register through one flat register port. A write takes effect at the clock edge on which the write strobe is sampled. A read returns the value combinationally for the address currently presented. The address is `{sel[1:0], idx[1:0]}`:
- sel 0 addresses the status register of bank idx.
- sel 1 addresses the enable register of bank idx.
- sel 2 addresses the control registers: idx 0 is the global enable (bit 0), idx 1 is the pin-watch mask (bit n for bank n), and idx 2 is the capability register.

Top module: `bank_irq_unit`

## Requirements
- R1: After synchronous reset, every status and enable register, the global enable and the pin-watch mask read 0, and `irq_o` is low.
- R2: A 0-to-1 transition on an event input sets its status bit at the next clock edge. An input held high sets the bit only once: after the bit is cleared it stays clear while the input remains high.
- R3: A write to a status register (sel 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event rises in the same cycle as a write-one clear of the same status bit, the bit ends up set.
- R5: Each bank's enable register (sel 1) holds the value last written to it, and changes only on a write to it. Events and enables of one bank never change the registers of another bank.
- R6: `irq_o` is high exactly when the global enable is 1 and some bank has a status bit and its matching enable bit both set.
- R7: With the global enable (sel 2, idx 0, bit 0) at 0, `irq_o` stays low whatever the status and enable registers hold.
- R8: A rising edge on `rb_ready_i[n]` of a watched bank sets bit 0 of bank n's status register on the third clock edge after the pin change is sampled, and not earlier.
- R9: The ready/busy pin of a bank whose pin-watch mask bit (sel 2, idx 1) is 0 never sets a status bit, and a falling edge on any pin never sets one.
- R10: The capability register (sel 2, idx 2) reads the base-2 logarithm of the bank count in bits 3:0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_BANKS*EVT_W | Event inputs; bank n occupies bits n*EVT_W and up |
| rb_ready_i | input | NUM_BANKS | Asynchronous ready/busy pins, high means ready |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2+IDX_W | Register address {sel, idx} |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
A table of vectors runs one event pattern per bank against an enable pattern and a global enable setting. The patterns cover a single overlapping bit, disjoint bits, several bits with only one enabled, no event at all, and a global enable of 0. This separates the masking by enables from the gating by the global flag, and it also shows whether a neighbouring bank is disturbed. Directed tests then cover the cases the table cannot reach. They apply a partial write-one clear and an event held high across a clear. They make an event collide with a clear of the same bit. They check the ready bit one cycle before and at the cycle it is due to appear, and they drive pins on unwatched banks and falling edges. Finally they write to the read-only capability register.

// File: rtl/bank_irq_pkg.sv
// Shared register selector encoding and control-register indices for the
// per-bank interrupt status unit. Assumes a two-bit selector field on top of
// the register address.
package bank_irq_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_GLOBAL = 0;
    localparam int CTRL_PINMSK = 1;
    localparam int CTRL_CAPS   = 2;

endpackage

// File: rtl/bank_irq_rb_sync.sv
// Two-flop synchroniser and rising-edge detector for every bank's ready/busy
// pin. Assumes the pins are asynchronous and high when ready. All flops reset
// to 1, so reset release never reports an edge.
module bank_irq_rb_sync #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] rb_i,
    output logic [NUM_BANKS-1:0] rise_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pin
        logic meta_q, sync_q, last_q;

        // Resynchronise the pin and keep the previous synchronised level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                last_q <= 1'b1;
            end else begin
                meta_q <= rb_i[b];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        // Flag a low-to-high transition of the synchronised level.
        assign rise_o[b] = sync_q & ~last_q;
    end

endmodule

// File: rtl/bank_irq_bank_regs.sv
// Status and enable registers of one bank. Status bits are set on rising
// event inputs and cleared by write-one. A new event beats a clear in the
// same cycle. Assumes the event inputs are synchronous to clk.
module bank_irq_bank_regs #(
    parameter int EVT_W   = 8,
    parameter int RDY_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             rdy_rise_i,
    input  logic             clr_we_i,
    input  logic             en_we_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [EVT_W-1:0] status_o,
    output logic [EVT_W-1:0] enable_o,
    output logic             hit_o
);

    logic [EVT_W-1:0] evt_last_q;
    logic [EVT_W-1:0] set_vec;
    logic [EVT_W-1:0] clr_vec;

    // Remember the previous level of every event input.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_last_q <= '0;
        else        evt_last_q <= evt_i;
    end

    // Collect the bits to set from event edges and the ready-pin edge.
    always_comb begin
        set_vec          = evt_i & ~evt_last_q;
        set_vec[RDY_BIT] = set_vec[RDY_BIT] | rdy_rise_i;
        clr_vec          = clr_we_i ? wdata_i : '0;
    end

    // Update status: clear by write-one, then apply sets so events win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_vec) | set_vec;
    end

    // Load the enable register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_o <= '0;
        else if (en_we_i) enable_o <= wdata_i;
    end

    // The bank requests service when an enabled status bit is set.
    assign hit_o = |(status_o & enable_o);

endmodule

// File: rtl/bank_irq_unit.sv
// Top of the per-bank interrupt status unit: register decode, control
// registers, per-bank register instances, read-back mux and the combined
// interrupt. Assumes NUM_BANKS is a power of two no smaller than 2, and
// DATA_W no smaller than EVT_W, NUM_BANKS and 4.
module bank_irq_unit
    import bank_irq_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int EVT_W     = 8,
    parameter  int DATA_W    = 16,
    parameter  int RDY_BIT   = 0,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int IDX_W     = (BANK_W < 2) ? 2 : BANK_W,
    localparam int ADDR_W    = 2 + IDX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*EVT_W-1:0] evt_i,
    input  logic [NUM_BANKS-1:0]       rb_ready_i,
    input  logic                       reg_we_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic                       irq_o
);

    localparam logic [IDX_W:0] BANKS_IDX = (IDX_W+1)'(NUM_BANKS);

    reg_sel_e                   sel;
    logic [IDX_W-1:0]           idx;
    logic [BANK_W-1:0]          bank;
    logic                       idx_is_bank;
    logic                       global_en_q;
    logic [NUM_BANKS-1:0]       pin_mask_q;
    logic [NUM_BANKS-1:0]       rb_rise;
    logic [NUM_BANKS-1:0]       bank_hit;
    logic [EVT_W-1:0]           status_arr [NUM_BANKS];
    logic [EVT_W-1:0]           enable_arr [NUM_BANKS];
    logic [NUM_BANKS*EVT_W-1:0] status_flat;
    logic [NUM_BANKS*EVT_W-1:0] enable_flat;

    // Split the address into selector and index fields.
    always_comb begin
        sel         = reg_sel_e'(reg_addr_i[ADDR_W-1 -: 2]);
        idx         = reg_addr_i[IDX_W-1:0];
        bank        = idx[BANK_W-1:0];
        idx_is_bank = ({1'b0, idx} < BANKS_IDX);
    end

    // Control registers: global enable and pin-watch mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            global_en_q <= 1'b0;
            pin_mask_q  <= '0;
        end else if (reg_we_i && sel == SEL_CTRL) begin
            if (idx == IDX_W'(CTRL_GLOBAL)) global_en_q <= reg_wdata_i[0];
            if (idx == IDX_W'(CTRL_PINMSK)) pin_mask_q  <= reg_wdata_i[NUM_BANKS-1:0];
        end
    end

    bank_irq_rb_sync #(
        .NUM_BANKS (NUM_BANKS)
    ) u_rb_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb_i   (rb_ready_i),
        .rise_o (rb_rise)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic clr_we, en_we;

        // Decode the per-bank write strobes.
        assign clr_we = reg_we_i && sel == SEL_STATUS && idx == IDX_W'(b);
        assign en_we  = reg_we_i && sel == SEL_ENABLE && idx == IDX_W'(b);

        bank_irq_bank_regs #(
            .EVT_W   (EVT_W),
            .RDY_BIT (RDY_BIT)
        ) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[b*EVT_W +: EVT_W]),
            .rdy_rise_i (rb_rise[b] & pin_mask_q[b]),
            .clr_we_i   (clr_we),
            .en_we_i    (en_we),
            .wdata_i    (reg_wdata_i[EVT_W-1:0]),
            .status_o   (status_arr[b]),
            .enable_o   (enable_arr[b]),
            .hit_o      (bank_hit[b])
        );

        assign status_flat[b*EVT_W +: EVT_W] = status_arr[b];
        assign enable_flat[b*EVT_W +: EVT_W] = enable_arr[b];
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_STATUS: if (idx_is_bank) reg_rdata_o[EVT_W-1:0] = status_arr[bank];
            SEL_ENABLE: if (idx_is_bank) reg_rdata_o[EVT_W-1:0] = enable_arr[bank];
            SEL_CTRL: begin
                if (idx == IDX_W'(CTRL_GLOBAL)) reg_rdata_o[0] = global_en_q;
                if (idx == IDX_W'(CTRL_PINMSK)) reg_rdata_o[NUM_BANKS-1:0] = pin_mask_q;
                if (idx == IDX_W'(CTRL_CAPS))   reg_rdata_o[3:0] = 4'(BANK_W);
            end
            default: reg_rdata_o = '0;
        endcase
    end

    // Combined interrupt, gated by the global enable.
    assign irq_o = global_en_q & (|bank_hit);

endmodule

// File: rtl/bank_irq_unit_chk.sv
// Property checker for bank_irq_unit, attached by bind. Observes ports and
// the flattened register state only.
module bank_irq_unit_chk #(
    parameter int NUM_BANKS = 4,
    parameter int EVT_W     = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we_i,
    input logic [ADDR_W-1:0]          reg_addr_i,
    input logic [DATA_W-1:0]          reg_rdata_o,
    input logic                       irq_o,
    input logic [NUM_BANKS*EVT_W-1:0] status_flat,
    input logic [NUM_BANKS*EVT_W-1:0] enable_flat,
    input logic                       global_en_q,
    input logic [NUM_BANKS-1:0]       pin_mask_q
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en_q |-> !irq_o) else $error("irq without global enable"); // R7

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(status_flat & enable_flat))) else $error("irq without source"); // R6

    AST_STATUS_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_flat) & ~status_flat)) |->
            ($past(reg_we_i) && $past(reg_addr_i[ADDR_W-1 -: 2]) == 2'd0))
        else $error("status cleared without write"); // R3

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we_i) |-> $stable(enable_flat)) else $error("enable changed"); // R5

    AST_PINMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we_i) |-> $stable(pin_mask_q)) else $error("pin mask changed"); // R9

    AST_CAPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'({2'd2, 2'd2})) |->
            (reg_rdata_o[3:0] == 4'($clog2(NUM_BANKS))))
        else $error("capability value"); // R10

endmodule

bind bank_irq_unit bank_irq_unit_chk #(
    .NUM_BANKS (NUM_BANKS),
    .EVT_W     (EVT_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .status_flat (status_flat),
    .enable_flat (enable_flat),
    .global_en_q (global_en_q),
    .pin_mask_q  (pin_mask_q)
);

// File: tb/test_bank_irq_unit.sv
module test_bank_irq_unit;

    localparam int NB = 4;
    localparam int EW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*EW-1:0] evt = '0;
    logic [NB-1:0] rb = '1;
    logic          we = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_irq_unit #(.NUM_BANKS(NB), .EVT_W(EW), .DATA_W(DW)) i_bank_irq_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rb_ready_i(rb),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // Vector fields: bank[19:18] event[17:10] enable[9:2] global[1] irq[0]
    localparam logic [19:0] VEC [6] = '{
        {2'd0, 8'h01, 8'h01, 1'b1, 1'b1},
        {2'd1, 8'h02, 8'h01, 1'b1, 1'b0},
        {2'd2, 8'h80, 8'hFF, 1'b0, 1'b0},
        {2'd3, 8'h3C, 8'h04, 1'b1, 1'b1},
        {2'd1, 8'h00, 8'hFF, 1'b1, 1'b0},
        {2'd2, 8'h81, 8'h80, 1'b1, 1'b1}
    };

    function automatic logic [3:0] ad(input int s, input int i);
        return {2'(s), 2'(i)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        addr = a;
        #0.5;
        d = int'(rdata);
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state, R10 capability
        for (int b = 0; b < NB; b++) begin
            rd(ad(0, b), v); chk("R1 status", v, 0);
            rd(ad(1, b), v); chk("R1 enable", v, 0);
        end
        rd(ad(2, 0), v); chk("R1 global", v, 0);
        rd(ad(2, 1), v); chk("R1 pinmask", v, 0);
        chk("R1 irq", int'(irq), 0);
        rd(ad(2, 2), v); chk("R10 caps", v, 2);

        // Vector table: R2, R5, R6, R7
        for (int i = 0; i < 6; i++) begin
            int b; int ev; int en; int g; int ex;
            b = int'(VEC[i][19:18]); ev = int'(VEC[i][17:10]);
            en = int'(VEC[i][9:2]); g = int'(VEC[i][1]); ex = int'(VEC[i][0]);
            wr(ad(1, b), DW'(en));
            wr(ad(2, 0), DW'(g));
            @(negedge clk); evt[b*EW +: EW] = EW'(ev);
            @(negedge clk); evt = '0;
            rd(ad(0, b), v); chk("R2 status set", v, ev);
            rd(ad(1, b), v); chk("R5 enable readback", v, en);
            rd(ad(0, b ^ 1), v); chk("R5 other bank", v, 0);
            chk("R6 R7 irq", int'(irq), ex);
            wr(ad(0, b), 16'h00FF);
            wr(ad(1, b), 16'h0000);
            rd(ad(0, b), v); chk("R3 cleared", v, 0);
            chk("R6 irq idle", int'(irq), 0);
        end

        // R3 partial clear
        @(negedge clk); evt[7:0] = 8'h0F;
        @(negedge clk); evt = '0;
        wr(ad(0, 0), 16'h0005);
        rd(ad(0, 0), v); chk("R3 partial clear", v, 8'h0A);
        wr(ad(0, 0), 16'h0000);
        rd(ad(0, 0), v); chk("R3 zero write", v, 8'h0A);
        wr(ad(0, 0), 16'h00FF);

        // R2 held input sets once
        @(negedge clk); evt[1] = 1'b1;
        cyc(2);
        rd(ad(0, 0), v); chk("R2 held set", v, 8'h02);
        wr(ad(0, 0), 16'h0002);
        cyc(3);
        rd(ad(0, 0), v); chk("R2 held no reset", v, 0);
        evt = '0;
        cyc(1);

        // R4 event beats clear in the same cycle
        @(negedge clk);
        evt[EW + 3] = 1'b1; we = 1'b1; addr = ad(0, 1); wdata = 16'h0008;
        @(negedge clk);
        we = 1'b0; evt = '0;
        rd(ad(0, 1), v); chk("R4 event wins", v, 8'h08);
        wr(ad(0, 1), 16'h00FF);

        // R7 global gating, R6 recovery
        @(negedge clk); evt[4] = 1'b1;
        @(negedge clk); evt = '0;
        wr(ad(1, 0), 16'h0010);
        wr(ad(2, 0), 16'h0000);
        chk("R7 gated", int'(irq), 0);
        wr(ad(2, 0), 16'h0001);
        chk("R6 ungated", int'(irq), 1);
        wr(ad(0, 0), 16'h00FF);
        chk("R6 cleared irq", int'(irq), 0);

        // R8 ready edge latency on watched bank 2
        wr(ad(2, 1), 16'h0004);
        @(negedge clk); rb[2] = 1'b0;
        cyc(4);
        rd(ad(0, 2), v); chk("R9 falling edge", v, 0);
        rb[2] = 1'b1;
        cyc(2);
        rd(ad(0, 2), v); chk("R8 not early", v, 0);
        cyc(1);
        rd(ad(0, 2), v); chk("R8 ready bit", v, 1);
        wr(ad(0, 2), 16'h0001);

        // R9 unwatched bank 1
        @(negedge clk); rb[1] = 1'b0;
        cyc(4);
        rb[1] = 1'b1;
        cyc(5);
        rd(ad(0, 1), v); chk("R9 unwatched", v, 0);

        // R10 writes ignored
        wr(ad(2, 2), 16'hFFFF);
        rd(ad(2, 2), v); chk("R10 write ignored", v, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule